// File: doc/BRIEF.md
# Quadrature Phase-Counting Timer Channel

This block is one timer channel that tracks position from a two-wire encoder. The two encoder inputs, A and B, are asynchronous. Each one passes through a two-flop synchroniser and an edge detector. A mode field then decides which edges move a 16-bit position counter, and in which direction. The counter runs in the system clock domain and takes at most one step per clock.

A compare register can act as a ceiling. When the clear source selects it, counting up past the ceiling returns the counter to zero, and counting down from zero reloads the ceiling. A status bit shows the direction of the most recent step. A start register holds one run bit per channel, and this channel obeys the bit at its own index. Software reaches every register through a single synchronous write port with a combinational read-back.

Top module: `qpc_timer`

## Requirements
- R1: After reset the registers read as follows: counter 0x0000, ceiling 0xFFFF, mode 4, clear source 1, status 0x0080 and start 0x0000. The address map is counter 0, ceiling 1, mode 2 (low 4 bits), clear source 3 (low 3 bits), status 4 (read-only) and start 5 (one bit per channel).
- R2: With mode 4 (x4 quadrature), every edge of A or B moves the counter by one. The count goes up when A leads B and down when B leads A. Taking the pair as (A,B), the forward cycle is 00, 10, 11, 01.
- R3: With mode 5 (pulse plus direction), only a rising edge of A counts. It counts up when B is high and down when B is low. A falling edge of A, and any edge of B, leave the count unchanged.
- R4: With mode 7 (x2 on B), every edge of B counts. The count goes up when the new A equals the new B and down otherwise. Edges of A do not count.
- R5: With any other mode value (including 6 and 9), no input activity changes the counter.
- R6: With clear source 1, a step up while the counter equals the ceiling gives 0, and a step down from 0 gives the ceiling.
- R7: With any other clear source, the counter wraps over the full 16-bit range: 0xFFFF steps up to 0, and 0 steps down to 0xFFFF.
- R8: Bit 7 of the status register is 1 if the last step was up and 0 if it was down. It resets to 1.
- R9: While bit CH_IDX (default 1) of the start register is 0, the counter holds its value. The other start bits have no effect on this channel.
- R10: A software write to the counter in the same cycle as a count step wins, and the counter takes the written value.
- R11: In x4 mode, a simultaneous change of A and B is an invalid transition and does not count.
- R12: A change on an encoder input shows in the counter on the third rising clock edge after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |

## Verification
The hardest case to reach from the ports is a software write that falls in exactly the cycle when an encoder step takes effect. The bench gets there by using the fixed three-edge latency. It changes an input on a falling edge, waits two more falling edges, and then raises the write strobe so that it spans the third rising edge. The decode itself is covered by driving all sixteen previous/next pairs of (A,B) in every mode, including reserved values. This covers double changes and reversals, and the count is checked against an arithmetic model after each move.

// File: rtl/qpc_timer.sv
module qpc_timer #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 8,
  parameter int CH_IDX = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata
);
  localparam logic [2:0] A_CNT = 3'd0, A_CEIL = 3'd1, A_MODE = 3'd2,
                         A_CLR = 3'd3, A_STAT = 3'd4, A_START = 3'd5;
  localparam logic [3:0] M_X4 = 4'd4, M_PD = 4'd5, M_X2B = 4'd7;
  localparam logic [2:0] CLR_CMP = 3'd1;
  localparam int DIR_BIT = 7;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0]        a_sh, b_sh;
  logic [CNT_W-1:0]  cnt_q, ceil_q;
  logic [3:0]        mode_q;
  logic [2:0]        clr_q;
  logic [NUM_CH-1:0] start_q;
  logic              dir_q;

  logic a_now, b_now, a_edge, b_edge, a_rise;
  logic hit, step_up, step, en, cnt_wr, cmp_clr;
  logic [CNT_W-1:0] up_next, dn_next;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_sh <= '0;
      b_sh <= '0;
    end else begin
      a_sh <= {a_sh[1:0], enc_a};
      b_sh <= {b_sh[1:0], enc_b};
    end

  assign a_now  = a_sh[1];
  assign b_now  = b_sh[1];
  assign a_edge = a_sh[1] ^ a_sh[2];
  assign b_edge = b_sh[1] ^ b_sh[2];
  assign a_rise = a_sh[1] & ~a_sh[2];

  always_comb begin
    hit     = 1'b0;
    step_up = 1'b0;
    case (mode_q)
      M_X4: begin
        hit     = a_edge ^ b_edge;
        step_up = a_edge ? (a_now ^ b_now) : ~(a_now ^ b_now);
      end
      M_PD: begin
        hit     = a_rise;
        step_up = b_now;
      end
      M_X2B: begin
        hit     = b_edge;
        step_up = ~(a_now ^ b_now);
      end
      default: ;
    endcase
  end

  assign en      = start_q[CH_IDX];
  assign step    = hit & en;
  assign cnt_wr  = reg_we && (reg_addr == A_CNT);
  assign cmp_clr = (clr_q == CLR_CMP);
  assign up_next = (cmp_clr && cnt_q == ceil_q) ? '0 : cnt_q + 1'b1;
  assign dn_next = (cnt_q == '0) ? (cmp_clr ? ceil_q : CNT_MAX) : cnt_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else begin
      if (cnt_wr)    cnt_q <= reg_wdata;
      else if (step) cnt_q <= step_up ? up_next : dn_next;
      if (step)      dir_q <= step_up;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ceil_q  <= CNT_MAX;
      mode_q  <= M_X4;
      clr_q   <= CLR_CMP;
      start_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CEIL:  ceil_q  <= reg_wdata;
        A_MODE:  mode_q  <= reg_wdata[3:0];
        A_CLR:   clr_q   <= reg_wdata[2:0];
        A_START: start_q <= reg_wdata[NUM_CH-1:0];
        default: ;
      endcase
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CNT:   reg_rdata = cnt_q;
      A_CEIL:  reg_rdata = ceil_q;
      A_MODE:  reg_rdata[3:0] = mode_q;
      A_CLR:   reg_rdata[2:0] = clr_q;
      A_STAT:  reg_rdata[DIR_BIT] = dir_q;
      A_START: reg_rdata[NUM_CH-1:0] = start_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/qpc_timer_chk.sv
module qpc_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] ceil,
  input logic [3:0]       mode,
  input logic [2:0]       clr_sel,
  input logic             en,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] wdata,
  input logic             step,
  input logic             step_up,
  input logic             dir
);
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> $stable(count)); // R9
  AST_RESERVED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 4'd4 && mode != 4'd5 && mode != 4'd7 && !cnt_wr) |=> $stable(count)); // R5
  AST_CEIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && step_up && clr_sel == 3'd1 && count == ceil && !cnt_wr) |=> (count == '0)); // R6
  AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !step_up && clr_sel == 3'd1 && count == '0 && !cnt_wr) |=> (count == $past(ceil))); // R6
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !step_up && clr_sel != 3'd1 && count == '0 && !cnt_wr) |=> (count == '1)); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count == $past(wdata))); // R10
  AST_DIR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (dir == $past(step_up))); // R8
endmodule

bind qpc_timer qpc_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .count(cnt_q), .ceil(ceil_q), .mode(mode_q),
  .clr_sel(clr_q), .en(en), .cnt_wr(cnt_wr), .wdata(reg_wdata),
  .step(step), .step_up(step_up), .dir(dir_q)
);

// File: tb/qpc_timer_tb_top.sv
module qpc_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, enc_a = 1'b0, enc_b = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  qpc_timer dut_i (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] m_cnt = 0, m_ceil = 16'hFFFF;
  logic [3:0]  m_mode = 4'd4;
  logic [2:0]  m_clr = 3'd1;
  bit m_en = 0, m_dir = 1;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic int exp_delta(bit pa, bit pb, bit na, bit nb);
    case (m_mode)
      4'd4: begin
        if (pa != na && pb != nb) return 0;
        if (pa != na) return (na != nb) ? 1 : -1;
        if (pb != nb) return (na == nb) ? 1 : -1;
        return 0;
      end
      4'd5: return (!pa && na) ? (nb ? 1 : -1) : 0;
      4'd7: return (pb != nb) ? ((na == nb) ? 1 : -1) : 0;
      default: return 0;
    endcase
  endfunction

  task automatic model_step(int d);
    if (d > 0) m_cnt = (m_clr == 3'd1 && m_cnt == m_ceil) ? 16'h0 : m_cnt + 16'h1;
    else       m_cnt = (m_cnt == 16'h0) ? ((m_clr == 3'd1) ? m_ceil : 16'hFFFF) : m_cnt - 16'h1;
    m_dir = (d > 0);
  endtask

  task automatic move(bit na, bit nb, string tag);
    int d;
    logic [15:0] v;
    d = exp_delta(enc_a, enc_b, na, nb);
    enc_a = na; enc_b = nb;
    repeat (4) @(negedge clk);
    if (d != 0 && m_en) model_step(d);
    rd(3'd0, v); check(tag, v, m_cnt);
    rd(3'd4, v); check({tag, ",R8 status"}, v, {8'h0, m_dir, 7'h0});
  endtask

  function automatic int pos_of(bit a, bit b);
    return {a, b} == 2'b00 ? 0 : {a, b} == 2'b10 ? 1 : {a, b} == 2'b11 ? 2 : 3;
  endfunction

  task automatic qstep(int dir, string tag);
    int p;
    logic [1:0] g;
    p = (pos_of(enc_a, enc_b) + dir + 4) % 4;
    g = (p == 0) ? 2'b00 : (p == 1) ? 2'b10 : (p == 2) ? 2'b11 : 2'b01;
    move(g[1], g[0], tag);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rd(3'd0, v); check("R1 count", v, 16'h0000);
    rd(3'd1, v); check("R1 ceiling", v, 16'hFFFF);
    rd(3'd2, v); check("R1 mode", v, 16'h0004);
    rd(3'd3, v); check("R1 clear", v, 16'h0001);
    rd(3'd4, v); check("R1 status", v, 16'h0080);
    rd(3'd5, v); check("R1 start", v, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 3; i++) qstep(1, "R9 stopped");
    wr(3'd5, 16'h0002); m_en = 1;

    for (int i = 0; i < 10; i++) qstep(1, "R2 up");
    for (int i = 0; i < 14; i++) qstep(-1, "R2,R6 down");

    wr(3'd1, 16'h0005); m_ceil = 16'h0005;
    wr(3'd0, 16'h0003); m_cnt = 16'h0003;
    for (int i = 0; i < 4; i++) qstep(1, "R6 ceiling up");
    for (int i = 0; i < 3; i++) qstep(-1, "R6 ceiling down");

    wr(3'd3, 16'h0000); m_clr = 3'd0;
    wr(3'd0, 16'h0004); m_cnt = 16'h0004;
    for (int i = 0; i < 3; i++) qstep(1, "R7 past ceiling");
    wr(3'd0, 16'hFFFE); m_cnt = 16'hFFFE;
    for (int i = 0; i < 3; i++) qstep(1, "R7 top wrap");
    for (int i = 0; i < 3; i++) qstep(-1, "R7 bottom wrap");
    wr(3'd3, 16'h0001); m_clr = 3'd1;
    wr(3'd1, 16'hFFFF); m_ceil = 16'hFFFF;

    move(~enc_a, ~enc_b, "R11 double change");
    move(~enc_a, ~enc_b, "R11 double change back");

    begin
      logic [3:0] modes [7] = '{4'd4, 4'd5, 4'd7, 4'd6, 4'd9, 4'd0, 4'd15};
      foreach (modes[k]) begin
        string tag;
        wr(3'd2, {12'h0, modes[k]}); m_mode = modes[k];
        rd(3'd2, v); check("R5 mode readback", v, {12'h0, modes[k]});
        tag = (modes[k] == 4'd4) ? "R2,R11 sweep" : (modes[k] == 4'd5) ? "R3 sweep" :
              (modes[k] == 4'd7) ? "R4 sweep" : "R5 sweep";
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++) begin
            move(i[1], i[0], tag);
            move(j[1], j[0], tag);
          end
      end
    end
    wr(3'd2, 16'h0004); m_mode = 4'd4;

    wr(3'd5, 16'hFFFD); m_en = 0;
    rd(3'd5, v); check("R9 start readback", v, 16'h00FD);
    for (int i = 0; i < 4; i++) qstep(1, "R9 other bits set");
    wr(3'd5, 16'h0002); m_en = 1;

    // R10: write lands on the step cycle (third rising edge after input change)
    begin
      int p;
      p = pos_of(enc_a, enc_b);
      {enc_a, enc_b} = (p == 0) ? 2'b10 : (p == 1) ? 2'b11 : (p == 2) ? 2'b01 : 2'b00;
      @(negedge clk); @(negedge clk);
      reg_addr = 3'd0; reg_wdata = 16'h1234; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
      m_cnt = 16'h1234; m_dir = 1;
      rd(3'd0, v); check("R10 write wins", v, 16'h1234);
      rd(3'd4, v); check("R8 dir after collision", v, 16'h0080);
      repeat (2) @(negedge clk);
      rd(3'd0, v); check("R10 settled", v, 16'h1234);
    end

    // R12: latency of three rising edges
    begin
      int p;
      p = pos_of(enc_a, enc_b);
      {enc_a, enc_b} = (p == 0) ? 2'b01 : (p == 1) ? 2'b00 : (p == 2) ? 2'b10 : 2'b11;
      @(negedge clk); @(negedge clk);
      rd(3'd0, v); check("R12 not yet", v, 16'h1234);
      @(negedge clk);
      rd(3'd0, v); check("R12 third edge", v, 16'h1233);
      rd(3'd4, v); check("R8 down", v, 16'h0000);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule